// File: doc/BRIEF.md
# Link request serializer

This block sits on the link side of a serial-bus physical layer and turns one request from the link into a short serial frame. The frame goes out on a single request line, one bit per system clock. The link picks one of four request kinds: bus access, register read, register write or arbitration-acceleration control. It also presents the fields that kind needs and pulses a start strobe. The block captures everything on the accepting edge and shifts the frame out, first bit first. It holds a busy flag high until the final bit has been sent.

Every frame opens with a 1 and carries a 3-bit kind code next. The fields that follow depend on the kind, and a 0 closes the frame. The frame length therefore changes with the kind, from 6 bits up to 17 bits for a register write. Deciding when to issue a request, and reacting to what the physical layer answers, are left to surrounding logic.

Top module: `lreq_ser`

## Requirements
- R1: After reset, and whenever busy_o is low, lreq_o is 0 and busy_o is 0.
- R2: A start_i sampled high on a rising clock edge while busy_o is low accepts a request. In the next cycle busy_o is 1 and lreq_o carries frame bit 0, which is always 1. Frame bit n is on lreq_o in the n-th cycle after that one.
- R3: Frame bits 1 to 3 carry the kind code, highest code bit first. kind_i 0 (bus access) sends 001, kind_i 1 (register read) sends 100, kind_i 2 (register write) sends 101, and kind_i 3 (acceleration control) sends 110.
- R4: A register write is 17 bits long. Bits 4 to 7 hold addr_i and bits 8 to 15 hold data_i, each highest bit first, and bit 16 is 0.
- R5: A register read is 9 bits long. Bits 4 to 7 hold addr_i, highest bit first, and bit 8 is 0.
- R6: A bus access request is 8 bits long. Bits 4 to 6 hold speed_i, highest bit first, and bit 7 is 0.
- R7: An acceleration control request is 6 bits long. Bit 4 holds accel_en_i and bit 5 is 0.
- R8: busy_o stays high for exactly the frame length in cycles, starting with the cycle after acceptance. It is low in the cycle after the last bit.
- R9: A start_i sampled while busy_o is high is ignored. This also holds on the edge that ends the final bit, so at least one idle cycle separates two frames.
- R10: The fields are captured at acceptance. Changing kind_i, addr_i, data_i, speed_i or accel_en_i while busy_o is high does not alter the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| kind_i | input | 2 | Request kind: 0 bus, 1 read, 2 write, 3 accel |
| addr_i | input | 4 | Register address |
| data_i | input | 8 | Register write data |
| speed_i | input | 3 | Speed field of a bus access request |
| accel_en_i | input | 1 | Enable flag of an acceleration control request |
| busy_o | output | 1 | Frame in progress |
| lreq_o | output | 1 | Serial request line |

## Verification
The two events that can fall in the same cycle are a new start strobe and the final bit of the frame in progress. The strobe arriving on the edge that retires the last bit is the sharpest case. The bench provokes this by holding start_i high through entire frames and by toggling it at random during frames. After each such frame it checks that busy_o is low and lreq_o is 0 in the cycle after the stop bit, which proves the strobe was dropped. Field inputs are also scrambled during frames, and every bit is still compared with a frame the bench builds from the requirements.

// File: rtl/lreq_ser_pkg.sv
package lreq_ser_pkg;
  typedef enum logic [1:0] {
    KIND_BUS   = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_ACCEL = 2'd3
  } req_kind_e;

  localparam int unsigned CODE_W = 3;
  localparam logic [CODE_W-1:0] CODE_BUS   = 3'b001;
  localparam logic [CODE_W-1:0] CODE_READ  = 3'b100;
  localparam logic [CODE_W-1:0] CODE_WRITE = 3'b101;
  localparam logic [CODE_W-1:0] CODE_ACCEL = 3'b110;
endpackage

// File: rtl/lreq_frame_build.sv
module lreq_frame_build
  import lreq_ser_pkg::*;
#(
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned SPD_W   = 3,
  parameter int unsigned FRAME_W = 1 + CODE_W + ADDR_W + DATA_W + 1,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  req_kind_e            kind_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    data_i,
  input  logic [SPD_W-1:0]     speed_i,
  input  logic                 accel_en_i,
  output logic [FRAME_W-1:0]   frame_o,
  output logic [LEN_W-1:0]     len_o
);
  localparam int unsigned READ_LEN  = 1 + CODE_W + ADDR_W + 1;
  localparam int unsigned BUS_LEN   = 1 + CODE_W + SPD_W + 1;
  localparam int unsigned ACCEL_LEN = 1 + CODE_W + 1 + 1;

  // frames are left aligned: frame_o[FRAME_W-1] leaves first
  always_comb begin
    unique case (kind_i)
      KIND_WRITE: begin
        frame_o = {1'b1, CODE_WRITE, addr_i, data_i, 1'b0};
        len_o   = LEN_W'(FRAME_W);
      end
      KIND_READ: begin
        frame_o = FRAME_W'({1'b1, CODE_READ, addr_i, 1'b0}) << (FRAME_W - READ_LEN);
        len_o   = LEN_W'(READ_LEN);
      end
      KIND_BUS: begin
        frame_o = FRAME_W'({1'b1, CODE_BUS, speed_i, 1'b0}) << (FRAME_W - BUS_LEN);
        len_o   = LEN_W'(BUS_LEN);
      end
      default: begin
        frame_o = FRAME_W'({1'b1, CODE_ACCEL, accel_en_i, 1'b0}) << (FRAME_W - ACCEL_LEN);
        len_o   = LEN_W'(ACCEL_LEN);
      end
    endcase
  end
endmodule

// File: rtl/lreq_shifter.sv
module lreq_shifter #(
  parameter int unsigned FRAME_W = 17,
  parameter int unsigned LEN_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               lreq_o,
  output logic               busy_o
);
  logic [FRAME_W-1:0] sh_q;
  logic [LEN_W-1:0]   cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= frame_i;
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      cnt_q <= cnt_q - LEN_W'(1);
    end
  end

  assign lreq_o = sh_q[FRAME_W-1];
  assign busy_o = (cnt_q != '0);

  // R8: loaded length becomes the busy window
  assert_len_load_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(len_i));
  // R9: an active frame is never restarted
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> cnt_q == $past(cnt_q) - LEN_W'(1));
  // R4: last bit of any frame is the 0 stop bit
  assert_stop_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LEN_W'(1)) |-> !lreq_o);
endmodule

// File: rtl/lreq_ser.sv
module lreq_ser
  import lreq_ser_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SPD_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [SPD_W-1:0]  speed_i,
  input  logic              accel_en_i,
  output logic              busy_o,
  output logic              lreq_o
);
  localparam int unsigned FRAME_W = 1 + CODE_W + ADDR_W + DATA_W + 1;
  localparam int unsigned LEN_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic               accept;

  assign accept = start_i && !busy_o;

  lreq_frame_build #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPD_W(SPD_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_build (
    .kind_i    (req_kind_e'(kind_i)),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .speed_i   (speed_i),
    .accel_en_i(accel_en_i),
    .frame_o   (frame),
    .len_o     (len)
  );

  lreq_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .frame_i(frame),
    .len_i  (len),
    .lreq_o (lreq_o),
    .busy_o (busy_o)
  );

  // R1: line quiet outside frames
  assert_idle_low_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !lreq_o);
  // R2: accepted request opens with a 1 and raises busy
  assert_start_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (lreq_o && busy_o));
endmodule

// File: tb/lreq_ser_test.sv
module lreq_ser_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] kind = '0;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic [2:0] spd = '0;
  logic       aen = 1'b0;
  logic       busy, lreq;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  lreq_ser uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .kind_i(kind),
    .addr_i(addr), .data_i(data), .speed_i(spd), .accel_en_i(aen),
    .busy_o(busy), .lreq_o(lreq)
  );

  task automatic chk(bit ok, string rq, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, expv, $time);
    end
  endtask

  // expected bit sequence, element i = frame bit i
  function automatic int build(int k, logic [3:0] a, logic [7:0] d,
                               logic [2:0] s, logic e, ref bit b[17]);
    int p;
    for (int i = 0; i < 17; i++) b[i] = 0;
    b[0] = 1;
    case (k)
      0: begin b[1]=0; b[2]=0; b[3]=1; end
      1: begin b[1]=1; b[2]=0; b[3]=0; end
      2: begin b[1]=1; b[2]=0; b[3]=1; end
      default: begin b[1]=1; b[2]=1; b[3]=0; end
    endcase
    p = 4;
    if (k == 2 || k == 1) for (int i = 3; i >= 0; i--) begin b[p] = a[i]; p++; end
    if (k == 2) for (int i = 7; i >= 0; i--) begin b[p] = d[i]; p++; end
    if (k == 0) for (int i = 2; i >= 0; i--) begin b[p] = s[i]; p++; end
    if (k == 3) begin b[p] = e; p++; end
    b[p] = 0;  // stop
    return p + 1;
  endfunction

  function automatic string tag(int k, int i);
    if (i == 0) return "R2";
    if (i < 4) return "R3";
    case (k)
      0: return "R6";
      1: return "R5";
      2: return "R4";
      default: return "R7";
    endcase
  endfunction

  // noisy: scramble fields and strobe during frame (R9, R10); hold: keep strobe high
  task automatic send(int k, logic [3:0] a, logic [7:0] d, logic [2:0] s,
                      logic e, bit noisy, bit hold);
    bit b[17];
    int len;
    @(negedge clk);
    kind = 2'(k); addr = a; data = d; spd = s; aen = e; start = 1'b1;
    len = build(k, a, d, s, e, b);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      chk(lreq == b[i], noisy ? {tag(k, i), "/R10"} : tag(k, i), lreq, b[i]);
      chk(busy == 1'b1, "R8", busy, 1);
      start = hold ? 1'b1 : (noisy ? 1'($urandom % 2) : 1'b0);
      if (noisy) begin
        kind = 2'($urandom); addr = 4'($urandom); data = 8'($urandom);
        spd = 3'($urandom); aen = 1'($urandom);
      end
    end
    @(negedge clk);
    chk(busy == 1'b0, "R8/R9", busy, 0);
    chk(lreq == 1'b0, "R1", lreq, 0);
    start = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1394));
    #1;
    chk(busy == 1'b0, "R1", busy, 0);
    chk(lreq == 1'b0, "R1", lreq, 0);
    start = 1'b1;  // strobe during reset is ignored
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R1", busy, 0);
    chk(lreq == 1'b0, "R1", lreq, 0);

    send(2, 4'hA, 8'h5C, 3'd0, 1'b0, 0, 0);
    send(2, 4'h0, 8'hFF, 3'd0, 1'b0, 0, 0);
    send(1, 4'hF, 8'h00, 3'd0, 1'b0, 0, 0);
    send(0, 4'h0, 8'h00, 3'd5, 1'b0, 0, 0);
    send(3, 4'h0, 8'h00, 3'd0, 1'b1, 0, 0);
    send(3, 4'hF, 8'hFF, 3'd7, 1'b0, 0, 0);
    // strobe held through the final bit: R9 collision
    send(3, 4'h3, 8'h11, 3'd2, 1'b1, 0, 1);
    send(2, 4'h6, 8'h81, 3'd1, 1'b0, 0, 1);
    for (int j = 0; j < 60; j++)
      send(int'($urandom % 4), 4'($urandom), 8'($urandom), 3'($urandom),
           1'($urandom), 1, (j % 5) == 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule